// File: doc/BRIEF.md
# Seven-Pin General-Purpose I/O Port

This block controls a bank of seven bidirectional pins through a small register interface. For each pin, software chooses whether the pad is driven and what level it drives. When the pad is not driven, software chooses whether a weak pull holds it high, holds it low, or leaves it floating. Software can read back the last value it wrote to the output register at any time, whatever the pin's direction. A read-only register always shows the synchronized level present on every pad, including pads that the block is driving.

Each pin has an edge detector, which software sets to catch either rising or falling edges. A detected edge sets a sticky per-pin flag, and software clears the flag by writing 1 to it. The interrupt output is high while any flag with its enable bit set is high. While the chip is in its low-power stop state, the same condition raises a wake request.

The register bus has one access cycle. A write happens on the clock edge at which the select and write strobes are both high. Read data depends only on the address and on register state.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the direction, output, enable, edge-select and flag registers read 0, and the pull register reads 0x1555. At the pins, pad_oe is 0, pad_pu is 0x7F and pad_pd is 0, and irq and wake are low.
- R2: Register address 0 holds the direction bits, where bit i = 1 makes pin i an output; pad_oe equals these bits. Address 1 holds the output bits, and pad_out equals these bits.
- R3: A read of address 1 returns the stored output bits, whether each pin is an input or an output.
- R4: Address 2 returns the pad levels two clock edges after they change. It returns these levels for output pins as well as input pins. Writes to address 2 change nothing.
- R5: Address 3 holds a two-bit pull code for each pin, with pin i at bits 2i+1:2i. Code 01 means pull-up, 10 means pull-down, and 00 or 11 means floating. A pull is applied only while the pin is an input, and pad_pu and pad_pd are never both high for the same pin.
- R6: At address 5, bit i = 0 selects rising edges for pin i and bit i = 1 selects falling edges. A selected edge sets flag bit i at address 6 on the third clock edge after the pad changes. An edge of the other polarity sets no flag.
- R7: Writing 1 to a bit at address 6 clears that flag, and writing 0 to a bit leaves it unchanged. If a clear and a new edge for the same pin fall on the same clock edge, the flag ends up set.
- R8: Address 4 holds the interrupt enable bits. irq is high exactly when some flag is set and its enable bit is set. A flag is recorded even while its enable bit is clear.
- R9: wake is high only while stop_mode is high and irq is high.
- R10: Unused register bits read as 0, address 7 reads as 0, and writes to address 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pad_in | input | 7 | Pad levels as seen by the input buffers |
| pad_out | output | 7 | Level driven on each pad |
| pad_oe | output | 7 | Output buffer enable for each pad |
| pad_pu | output | 7 | Weak pull-up enable for each pad |
| pad_pd | output | 7 | Weak pull-down enable for each pad |
| stop_mode | input | 1 | High while the chip is in its stop state |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request for the stop state |

## Verification
The assertions check four properties on every cycle:
- pad_oe follows each write to the direction register.
- No pin has both pulls on, and no output pin has a pull.
- Every new flag comes from a detected edge, and a detected edge always leaves its flag set, even when a clear happens on the same edge.
- Cleared flags stay clear, and wake never rises outside stop mode.

Only the bench's scenarios can show the other behaviours: the exact latency of the input register and of the flags, rejection of the non-selected polarity, and the register encodings and readback values.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Register offsets on the 3-bit address bus.
  typedef enum logic [2:0] {
    REG_DIR  = 3'd0,
    REG_OUT  = 3'd1,
    REG_IN   = 3'd2,
    REG_PULL = 3'd3,
    REG_IE   = 3'd4,
    REG_EDGE = 3'd5,
    REG_FLAG = 3'd6,
    REG_NONE = 3'd7
  } reg_sel_e;

  // Two-bit pull codes; 2'b11 is reserved and behaves as floating.
  localparam logic [1:0] PULL_FLOAT = 2'b00;
  localparam logic [1:0] PULL_HIGH  = 2'b01;
  localparam logic [1:0] PULL_LOW   = 2'b10;

  // Pull-up only for an undriven pin whose code asks for it.
  function automatic logic pull_up_en(input logic [1:0] code, input logic is_out);
    return (!is_out) && (code == PULL_HIGH);
  endfunction

  // Pull-down only for an undriven pin whose code asks for it.
  function automatic logic pull_dn_en(input logic [1:0] code, input logic is_out);
    return (!is_out) && (code == PULL_LOW);
  endfunction

  // Edge of the selected polarity between the previous and current sample.
  function automatic logic edge_match(input logic cur, input logic prev, input logic falling);
    return falling ? (prev && !cur) : (cur && !prev);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pad levels.
module gpio_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
// Per-pin edge detection and sticky write-one-to-clear flags.
module gpio_edge
  import gpio_pkg::*;
#(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,       // synchronized pad levels
  input  logic [N-1:0] sel_fall,  // 1 = falling, 0 = rising
  input  logic [N-1:0] clr_req,   // write-one-to-clear strobes
  output logic [N-1:0] edge_evt,  // selected edge seen this cycle
  output logic [N-1:0] flag_q
);
  logic [N-1:0] prev_q;

  // Previous sample; reset high to match the pull-up default.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign edge_evt[i] = edge_match(lvl[i], prev_q[i], sel_fall[i]);

    // A new edge takes priority over a clear on the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q[i] <= 1'b0;
      else if (edge_evt[i]) flag_q[i] <= 1'b1;
      else if (clr_req[i])  flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_pad_ctl.sv
// Decodes direction and pull codes into pad buffer and pull controls.
module gpio_pad_ctl
  import gpio_pkg::*;
#(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0]   dir,
  input  logic [2*N-1:0] pull,
  output logic [N-1:0]   oe,
  output logic [N-1:0]   pu,
  output logic [N-1:0]   pd
);
  assign oe = dir;

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign pu[i] = pull_up_en(pull[2*i +: 2], dir[i]);
    assign pd[i] = pull_dn_en(pull[2*i +: 2], dir[i]);
  end
endmodule

// File: rtl/gpio_regs.sv
// Register file and read multiplexer of the port.
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned N  = 7,
  parameter int unsigned DW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [2:0]     bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic [N-1:0]   in_lvl,
  input  logic [N-1:0]   flag_q,
  output logic [N-1:0]   dir_q,
  output logic [N-1:0]   out_q,
  output logic [2*N-1:0] pull_q,
  output logic [N-1:0]   ie_q,
  output logic [N-1:0]   fall_q,
  output logic [N-1:0]   flag_clr,
  output logic [DW-1:0]  bus_rdata
);
  localparam int unsigned PW = 2 * N;
  localparam logic [PW-1:0] PULL_RST = {N{PULL_HIGH}};

  reg_sel_e sel;
  logic     wr_en;
  logic     unused_wdata;

  assign sel   = reg_sel_e'(bus_addr);
  assign wr_en = bus_sel && bus_wr;
  // The pull field is the widest one; any bits above it are not stored.
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      pull_q <= PULL_RST;
      ie_q   <= '0;
      fall_q <= '0;
    end else if (wr_en) begin
      case (sel)
        REG_DIR:  dir_q  <= bus_wdata[N-1:0];
        REG_OUT:  out_q  <= bus_wdata[N-1:0];
        REG_PULL: pull_q <= bus_wdata[PW-1:0];
        REG_IE:   ie_q   <= bus_wdata[N-1:0];
        REG_EDGE: fall_q <= bus_wdata[N-1:0];
        default: ;
      endcase
    end
  end

  assign flag_clr = (wr_en && sel == REG_FLAG) ? bus_wdata[N-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    case (sel)
      REG_DIR:  bus_rdata[N-1:0]  = dir_q;
      REG_OUT:  bus_rdata[N-1:0]  = out_q;
      REG_IN:   bus_rdata[N-1:0]  = in_lvl;
      REG_PULL: bus_rdata[PW-1:0] = pull_q;
      REG_IE:   bus_rdata[N-1:0]  = ie_q;
      REG_EDGE: bus_rdata[N-1:0]  = fall_q;
      REG_FLAG: bus_rdata[N-1:0]  = flag_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
// Seven-pin general-purpose I/O port with pulls, edge flags and wake.
module gpio_bank #(
  parameter int unsigned N          = 7,
  parameter int unsigned DW         = 16,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  pad_in,
  output logic [N-1:0]  pad_out,
  output logic [N-1:0]  pad_oe,
  output logic [N-1:0]  pad_pu,
  output logic [N-1:0]  pad_pd,
  input  logic          stop_mode,
  output logic          irq,
  output logic          wake
);
  localparam int unsigned PW = 2 * N;

  // Internal events brought out as named wires for the checker.
  logic [N-1:0]  in_lvl;
  logic [N-1:0]  dir_q;
  logic [N-1:0]  out_q;
  logic [PW-1:0] pull_q;
  logic [N-1:0]  ie_q;
  logic [N-1:0]  fall_q;
  logic [N-1:0]  flag_clr;
  logic [N-1:0]  flag_q;
  logic [N-1:0]  edge_evt;
  logic [N-1:0]  irq_pend;

  gpio_sync #(.W(N), .STAGES(SYNC_DEPTH), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_lvl)
  );

  gpio_regs #(.N(N), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .in_lvl(in_lvl), .flag_q(flag_q),
    .dir_q(dir_q), .out_q(out_q), .pull_q(pull_q), .ie_q(ie_q), .fall_q(fall_q),
    .flag_clr(flag_clr), .bus_rdata(bus_rdata)
  );

  gpio_edge #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(in_lvl), .sel_fall(fall_q),
    .clr_req(flag_clr), .edge_evt(edge_evt), .flag_q(flag_q)
  );

  gpio_pad_ctl #(.N(N)) u_pad (
    .dir(dir_q), .pull(pull_q), .oe(pad_oe), .pu(pad_pu), .pd(pad_pd)
  );

  assign pad_out  = out_q;
  assign irq_pend = flag_q & ie_q;
  assign irq      = |irq_pend;
  assign wake     = stop_mode && irq;
endmodule

// File: rtl/gpio_bank_chk.sv
// Assertion checker bound into every gpio_bank instance.
module gpio_bank_chk #(
  parameter int unsigned N  = 7,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [N-1:0]  pad_oe,
  input logic [N-1:0]  pad_pu,
  input logic [N-1:0]  pad_pd,
  input logic          stop_mode,
  input logic          irq,
  input logic          wake,
  input logic [N-1:0]  flag_q,
  input logic [N-1:0]  edge_evt
);
  logic wr_dir, wr_flag;
  assign wr_dir  = bus_sel && bus_wr && (bus_addr == 3'd0);
  assign wr_flag = bus_sel && bus_wr && (bus_addr == 3'd6);

  p_dir_drives_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pad_oe == $past(bus_wdata[N-1:0])));

  p_pull_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_pd) == '0));

  p_no_pull_on_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_pu | pad_pd) & pad_oe) == '0));

  p_flag_from_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & ~$past(edge_evt)) == '0));

  p_edge_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(edge_evt) & ~flag_q) == '0));

  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag |=> ((flag_q & $past(bus_wdata[N-1:0]) & ~$past(edge_evt)) == '0));

  p_wake_needs_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (stop_mode && irq));

  p_wake_when_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && irq) |-> wake);
endmodule

bind gpio_bank gpio_bank_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_oe(pad_oe),
  .pad_pu(pad_pu), .pad_pd(pad_pd), .stop_mode(stop_mode), .irq(irq),
  .wake(wake), .flag_q(flag_q), .edge_evt(edge_evt)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  localparam logic [2:0] A_DIR = 3'd0, A_OUT = 3'd1, A_IN = 3'd2, A_PULL = 3'd3,
                         A_IE = 3'd4, A_EDGE = 3'd5, A_FLAG = 3'd6, A_NONE = 3'd7;

  // {address, write data, expected readback}
  localparam logic [34:0] VEC [NV] = '{
    {A_DIR,  16'hFFFF, 16'h007F},
    {A_OUT,  16'hFF2A, 16'h002A},
    {A_DIR,  16'h0000, 16'h0000},
    {A_OUT,  16'h0055, 16'h0055},
    {A_PULL, 16'hFFFF, 16'h3FFF},
    {A_PULL, 16'h1B1B, 16'h1B1B},
    {A_IE,   16'h00F0, 16'h0070},
    {A_EDGE, 16'h0003, 16'h0003},
    {A_IN,   16'h0000, 16'h007F},
    {A_NONE, 16'hFFFF, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [6:0] pad_in = 7'h7F;
  logic [6:0] pad_out, pad_oe, pad_pu, pad_pd;
  logic stop_mode = 1'b0;
  logic irq, wake;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .stop_mode(stop_mode), .irq(irq), .wake(wake)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pin_set(input logic [6:0] p);
    @(negedge clk);
    pad_in = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(A_DIR, v);  chk("R1 dir reset", v, 16'h0000);
    rd(A_OUT, v);  chk("R1 out reset", v, 16'h0000);
    rd(A_PULL, v); chk("R1 pull reset", v, 16'h1555);
    rd(A_IE, v);   chk("R1 enable reset", v, 16'h0000);
    rd(A_EDGE, v); chk("R1 edge reset", v, 16'h0000);
    rd(A_FLAG, v); chk("R1 flag reset", v, 16'h0000);
    chk("R1 pad_oe", {9'd0, pad_oe}, 16'h0000);
    chk("R1 pad_pu", {9'd0, pad_pu}, 16'h007F);
    chk("R1 pad_pd", {9'd0, pad_pd}, 16'h0000);
    chk("R1 irq/wake", {14'd0, irq, wake}, 16'h0000);

    // Table: write then read back (R2/R3/R4/R5/R8/R10 register behaviour)
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][34:32], VEC[k][31:16]);
      rd(VEC[k][34:32], v);
      chk($sformatf("R2/R3/R4/R5/R10 table entry %0d", k), v, VEC[k][15:0]);
    end

    do_reset();

    // R2 pad drive
    wr(A_DIR, 16'h000F);
    wr(A_OUT, 16'h0005);
    chk("R2 pad_oe", {9'd0, pad_oe}, 16'h000F);
    chk("R2 pad_out", {9'd0, pad_out}, 16'h0005);

    // R4 input latency, output pin 0 still visible
    pin_set(7'h7E);
    @(negedge clk); rd(A_IN, v); chk("R4 input after one edge", v, 16'h007F);
    @(negedge clk); rd(A_IN, v); chk("R4 input after two edges", v, 16'h007E);

    // R6 rising edge on pin 0 with enable off: R8 flag recorded, irq low
    pin_set(7'h7F);
    repeat (3) @(negedge clk);
    rd(A_FLAG, v); chk("R6 rising flag", v, 16'h0001);
    chk("R8 irq masked", {15'd0, irq}, 16'h0000);
    wr(A_FLAG, 16'h007F);
    rd(A_FLAG, v); chk("R7 clear all", v, 16'h0000);

    // R5 pull decode, pin 4 as output
    wr(A_DIR, 16'h0010);
    wr(A_PULL, 16'h1939);
    chk("R5 pad_pu", {9'd0, pad_pu}, 16'h0041);
    chk("R5 pad_pd", {9'd0, pad_pd}, 16'h0022);
    rd(A_PULL, v); chk("R5 pull readback", v, 16'h1939);
    rd(A_OUT, v);  chk("R3 out readback", v, 16'h0005);

    // R6 falling edge on pin 1, timing boundary
    wr(A_EDGE, 16'h0002);
    wr(A_IE, 16'h0002);
    pin_set(7'h7D);
    repeat (2) @(negedge clk);
    rd(A_FLAG, v); chk("R6 no flag before third edge", v, 16'h0000);
    @(negedge clk);
    rd(A_FLAG, v); chk("R6 falling flag on third edge", v, 16'h0002);
    chk("R8 irq enabled", {15'd0, irq}, 16'h0001);
    chk("R9 no wake when running", {15'd0, wake}, 16'h0000);
    stop_mode = 1'b1; #1;
    chk("R9 wake in stop", {15'd0, wake}, 16'h0001);

    // R7 writing zero keeps flag; R6 opposite polarity ignored
    wr(A_FLAG, 16'h0000);
    rd(A_FLAG, v); chk("R7 zero write keeps flag", v, 16'h0002);
    pin_set(7'h7F);
    repeat (4) @(negedge clk);
    rd(A_FLAG, v); chk("R6 rising ignored when falling selected", v, 16'h0002);
    wr(A_FLAG, 16'h0002);
    rd(A_FLAG, v); chk("R7 one clears", v, 16'h0000);
    chk("R9 wake drops", {14'd0, irq, wake}, 16'h0000);

    // R7 set wins over simultaneous clear
    pin_set(7'h7D);
    repeat (2) @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 16'h0002;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(A_FLAG, v); chk("R7 set wins over clear", v, 16'h0002);

    // R8 disabling masks irq, flag remains
    wr(A_IE, 16'h0000);
    chk("R8 irq off when disabled", {15'd0, irq}, 16'h0000);
    chk("R9 wake off when disabled", {15'd0, wake}, 16'h0000);
    rd(A_FLAG, v); chk("R8 flag kept while disabled", v, 16'h0002);
    stop_mode = 1'b0;

    // R10 write to unused address changes nothing
    wr(A_NONE, 16'hFFFF);
    rd(A_DIR, v); chk("R10 dir untouched", v, 16'h0010);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule